// File: doc/BRIEF.md
# Segmented Real-Mode Address Generator

This block turns a 16-bit segment and a 16-bit offset into a 20-bit byte address. The segment is shifted up four bit positions and the offset is added to it. Only the low 20 bits of the sum are kept. Because of this, many segment:offset pairs reach the same byte. A segment value selects a 64 KiB window, and the windows of neighbouring segment values start 16 bytes apart, so the windows overlap. Addresses that run past the top of the 1 MiB space wrap back to zero.

The block holds four untyped segment registers: extra, code, stack and data. Any of them can serve any access. A request can instead carry its own segment value. This is the far-transfer form, and it also loads that value into the code register. A separate write port reloads one register at a time. A caller uses it, for example, to point the extra register at a different buffer while the other three registers stay as they are. A request is accepted on every cycle that its valid is high, and its address appears on the registered output one cycle later.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset the extra, stack and data registers hold 0000h, the code register holds FFFFh, and addr_valid is low.
- R2: For an accepted request, addr equals (segment * 16 + offset) mod 2^20. It appears on the clock edge after the request, and addr_valid is high in the same cycle.
- R3: Sums beyond 20 bits wrap to the bottom of the space. For example, FFFF:0010 gives 00000h and FFFF:FFFF gives 0FFEFh.
- R4: Different pairs that name the same byte give the same address. For example, F000:FFF0 and FFFF:0000 both give FFFF0h.
- R5: req_sel picks the stored register: 00 = extra, 01 = code, 10 = stack, 11 = data. Any register may be used for any access.
- R6: When req_use_imm is 1, the request uses req_imm_seg instead of a stored register. It also writes that value into the code register. This far load overrides a write-port write to the code register in the same cycle.
- R7: A write-port write (wr_en, wr_sel with the same encoding as R5, wr_data) changes only the selected register, and the new value applies to later requests.
- R8: When a write and a stored-register request name the same register in the same cycle, the request uses the new value from wr_data.
- R9: Requests on consecutive cycles each produce an address on consecutive cycles. A cycle without a request leaves addr_valid low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Address request strobe |
| req_use_imm | input | 1 | Far form: use req_imm_seg and load it into the code register |
| req_sel | input | 2 | Stored segment register select |
| req_imm_seg | input | 16 | Segment value carried by the request |
| req_off | input | 16 | Offset within the segment window |
| wr_en | input | 1 | Segment register write enable |
| wr_sel | input | 2 | Segment register written |
| wr_data | input | 16 | Value written |
| addr_valid | output | 1 | Physical address valid |
| addr | output | 20 | Physical byte address |

## Verification
The hardest cases to reach are collisions inside a single cycle. One is a write to a register while a request reads that same register. The other is a far request that loads the code register while the write port targets it too. The bench drives both collisions on purpose. It also drives a long random stream in which the write port and the request select share a small set of values, so these collisions happen often. A behavioural model of the register file is compared with the outputs on every clock. It is written with an integer array and applies the override and bypass rules directly.

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  parameter logic [SEG_W-1:0] CODE_RST = '1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_use_imm,
  input  logic [1:0]             req_sel,
  input  logic [SEG_W-1:0]       req_imm_seg,
  input  logic [OFF_W-1:0]       req_off,
  input  logic                   wr_en,
  input  logic [1:0]             wr_sel,
  input  logic [SEG_W-1:0]       wr_data,
  output logic                   addr_valid,
  output logic [SEG_W+SHIFT-1:0] addr
);
  localparam int ADDR_W = SEG_W + SHIFT;
  localparam int NSEG = 4;
  localparam int CODE_IDX = 1;

  logic [NSEG-1:0][SEG_W-1:0] seg_q;
  logic                       valid_q;
  logic [ADDR_W-1:0]          addr_q;

  wire              far_ld  = req_valid && req_use_imm;
  wire              bypass  = wr_en && (wr_sel == req_sel);
  wire [SEG_W-1:0]  seg_eff = req_use_imm ? req_imm_seg :
                              bypass      ? wr_data     : seg_q[req_sel];
  wire [ADDR_W-1:0] sum     = {seg_eff, {SHIFT{1'b0}}} + ADDR_W'(req_off);

  always_ff @(posedge clk) begin
    for (int g = 0; g < NSEG; g++) begin
      if (!rst_n)
        seg_q[g] <= (g == CODE_IDX) ? CODE_RST : '0;
      else if (far_ld && g == CODE_IDX)
        seg_q[g] <= req_imm_seg;
      else if (wr_en && wr_sel == 2'(g))
        seg_q[g] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      valid_q <= req_valid;
      if (req_valid) addr_q <= sum;
    end
  end

  assign addr_valid = valid_q;
  assign addr       = addr_q;
endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_valid,
  input logic                       req_use_imm,
  input logic [SEG_W-1:0]           req_imm_seg,
  input logic [OFF_W-1:0]           req_off,
  input logic                       wr_en,
  input logic [1:0]                 wr_sel,
  input logic                       addr_valid,
  input logic [SEG_W+SHIFT-1:0]     addr,
  input logic [3:0][SEG_W-1:0]      seg_q
);
  localparam int ADDR_W = SEG_W + SHIFT;

  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> addr_valid); // R9
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !addr_valid); // R9
  AST_IMM_ADDRESS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_use_imm) |=>
      addr == ADDR_W'({$past(req_imm_seg), {SHIFT{1'b0}}} + ADDR_W'($past(req_off)))); // R2
  AST_FAR_LOADS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_use_imm) |=> seg_q[1] == $past(req_imm_seg)); // R6
  AST_EXTRA_WRITE_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0 && !(req_valid && req_use_imm)) |=> $stable(seg_q[3:1])); // R7
endmodule

bind seg_addr_gen seg_addr_gen_chk #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_use_imm(req_use_imm),
  .req_imm_seg(req_imm_seg), .req_off(req_off), .wr_en(wr_en), .wr_sel(wr_sel),
  .addr_valid(addr_valid), .addr(addr), .seg_q(seg_q)
);

// File: tb/seg_addr_gen_tb_top.sv
module seg_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_use_imm = 1'b0, wr_en = 1'b0;
  logic [1:0]  req_sel = '0, wr_sel = '0;
  logic [15:0] req_imm_seg = '0, req_off = '0, wr_data = '0;
  logic        addr_valid;
  logic [19:0] addr;

  int checks = 0, failures = 0, cycles = 0;
  int model [4];
  bit exp_valid;
  int exp_addr;

  always #4 clk = ~clk;

  seg_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_use_imm(req_use_imm),
    .req_sel(req_sel), .req_imm_seg(req_imm_seg), .req_off(req_off),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .addr_valid(addr_valid), .addr(addr)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%05h expected=%05h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input bit rv, input bit imm, input int sel,
                      input int iseg, input int off, input bit we, input int wsel,
                      input int wdata);
    int seg;
    req_valid = rv; req_use_imm = imm; req_sel = 2'(sel); req_imm_seg = 16'(iseg);
    req_off = 16'(off); wr_en = we; wr_sel = 2'(wsel); wr_data = 16'(wdata);
    if (imm) seg = iseg;
    else if (we && wsel == sel) seg = wdata;
    else seg = model[sel];
    exp_valid = rv;
    exp_addr = (seg * 16 + off) % (1 << 20);
    if (rv && imm) model[1] = iseg;
    if (we && !(rv && imm && wsel == 1)) model[wsel] = wdata;
    @(posedge clk);
    @(negedge clk);
    check(addr_valid == exp_valid, {tag, " valid"}, int'(addr_valid), int'(exp_valid));
    if (exp_valid) check(int'(addr) == exp_addr, {tag, " addr"}, int'(addr), exp_addr);
  endtask

  initial begin
    model = '{0, 32'hFFFF, 0, 0};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(addr_valid == 1'b0, "R1 reset valid", int'(addr_valid), 0);
    for (int s = 0; s < 4; s++) step("R1 reset regs", 1, 0, s, 0, 0, 0, 0, 0);
    step("R4 alias a", 1, 1, 0, 16'hF000, 16'hFFF0, 0, 0, 0);
    step("R4 alias b", 1, 1, 0, 16'hFFFF, 16'h0000, 0, 0, 0);
    step("R3 wrap zero", 1, 1, 0, 16'hFFFF, 16'h0010, 0, 0, 0);
    step("R3 wrap top", 1, 0, 1, 0, 16'hFFFF, 0, 0, 0);
    for (int s = 0; s < 4; s++) step("R7 load", 0, 0, 0, 0, 0, 1, s, 16'h1000 * (s + 1));
    for (int s = 0; s < 4; s++) step("R5 select", 1, 0, s, 0, 16'h0123, 0, 0, 0);
    step("R7 extra retarget", 0, 0, 0, 0, 0, 1, 0, 16'h8000);
    for (int s = 0; s < 4; s++) step("R7 isolation", 1, 0, s, 0, 16'h0004, 0, 0, 0);
    step("R8 bypass", 1, 0, 3, 0, 16'h0010, 1, 3, 16'hABCD);
    step("R8 after", 1, 0, 3, 0, 16'h0000, 0, 0, 0);
    step("R6 far over write", 1, 1, 2, 16'h2222, 16'h0001, 1, 1, 16'h7777);
    step("R6 code loaded", 1, 0, 1, 0, 16'h0000, 0, 0, 0);
    step("R9 idle", 0, 0, 0, 0, 0, 0, 0, 0);
    step("R9 b2b a", 1, 0, 0, 0, 16'h0001, 0, 0, 0);
    step("R9 b2b b", 1, 0, 2, 0, 16'h0002, 0, 0, 0);
    for (int i = 0; i < 400; i++)
      step("R2 random", $urandom_range(0, 3) != 0, $urandom_range(0, 5) == 0,
           $urandom_range(0, 3), $urandom_range(0, 16'hFFFF), $urandom_range(0, 16'hFFFF),
           $urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 16'hFFFF));
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end
endmodule